// File: doc/BRIEF.md
# Serial-Peripheral Configuration Bank with Write Guard

This block holds the configuration registers of a serial-peripheral controller behind a small synchronous register port. A protection-control register carries one enable bit. While that bit is set, software cannot change the two guarded configuration registers: the frame-mode register and the chip-select setup register. A data-holding register stays writable at all times.

A blocked write is not silently dropped. It sets a sticky violation flag and records the offset of the register it targeted. Both appear in a read-only status register. Reading the status register clears the flag. If a new violation arrives in the same cycle as that read, the violation wins and the flag stays set.

The port has separate write and read addresses, so a write and a read can occur in the same cycle. Read data is registered and appears one cycle after the read enable.

Top module: `spi_wp_top`

Register offsets: 0x04 frame mode (guarded), 0x08 data holding (unguarded), 0x10 chip-select setup (guarded), 0x20 protection control, 0x24 protection status (read-only).

## Requirements
- R1: After reset every register reads zero, protection is off, no violation is pending, and rd_data_o is zero.
- R2: Bit 0 of the protection control register (0x20) is the enable bit. It is writable at any time, and its other bits read as zero.
- R3: While the enable bit is clear, writes to 0x04 and 0x10 update those registers, and the new value reads back.
- R4: While the enable bit is set, a write to 0x04 or 0x10 leaves the targeted register unchanged.
- R5: The data-holding register at 0x08 is written whatever the state of the enable bit.
- R6: A write blocked under R4 sets the violation flag, which is bit 0 of the status register (0x24).
- R7: Status bits [15:8] hold the offset of the most recent blocked write. A later violation overwrites them before any read.
- R8: A status read returns the value held before the read and then clears the flag. The source field is kept.
- R9: If a violation and a status read occur in the same cycle, the flag is set afterwards and the source holds the new offset.
- R10: After a write that clears the enable bit, a guarded write in the next cycle takes effect.
- R11: rd_data_o shows the addressed register one cycle after rd_en_i and is zero in cycles after no read. Unmapped addresses read zero. Writes to unmapped addresses or to the status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write offset |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read offset |
| rd_data_o | output | DATA_W | Registered read data |

## Verification
The hardest case to reach is a blocked write that lands in the same cycle as a status read. The read then returns the older status while the flag is set again underneath it. The bench reaches this case by driving a guarded write and a status read together on the separate address ports. A follow-up read then confirms that the flag survived and that the source moved to the new offset. Back-to-back violations without an intervening read, and a guarded write in the cycle right after protection is dropped, are also driven deliberately.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam int NUM_CFG = 3;
  // configuration registers: frame mode, data holding, chip-select setup
  localparam logic [7:0] CFG_OFF   [NUM_CFG] = '{8'h04, 8'h08, 8'h10};
  localparam bit         CFG_GUARD [NUM_CFG] = '{1'b1, 1'b0, 1'b1};
  localparam logic [7:0] OFF_CTRL = 8'h20;
  localparam logic [7:0] OFF_STAT = 8'h24;
  localparam int         SRC_LSB  = 8;
endpackage

// File: rtl/spi_wp_guard.sv
module spi_wp_guard
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              en_wdata_i,
  input  logic              stat_rd_i,
  output logic              prot_en_o,
  output logic              wr_block_o,
  output logic              viol_flag_o,
  output logic [ADDR_W-1:0] viol_src_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic guard_hit;
  logic viol;

  always_comb begin
    guard_hit = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (CFG_GUARD[i] && (wr_addr_i == ADDR_W'(CFG_OFF[i]))) guard_hit = 1'b1;
    end
  end

  assign wr_block_o = prot_en_o && guard_hit;
  assign viol       = wr_en_i && wr_block_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_en_o <= 1'b0;
    end else if (wr_en_i && (wr_addr_i == A_CTRL)) begin
      prot_en_o <= en_wdata_i;
    end
  end

  // violation has priority over the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_flag_o <= 1'b0;
      viol_src_o  <= '0;
    end else if (viol) begin
      viol_flag_o <= 1'b1;
      viol_src_o  <= wr_addr_i;
    end else if (stat_rd_i) begin
      viol_flag_o <= 1'b0;
    end
  end

  // R6
  viol_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> viol_flag_o);
  // R7
  viol_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> (viol_src_o == $past(wr_addr_i)));
  // R8
  rd_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !viol) |=> !viol_flag_o);
  // R8
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol |=> $stable(viol_src_o));
  // R10
  unprotect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == A_CTRL) && !en_wdata_i) |=> !prot_en_o);
endmodule

// File: rtl/spi_wp_cfg_bank.sv
module spi_wp_cfg_bank
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic                            wr_block_i,
  output logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_q_o
);
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] A_REG = ADDR_W'(CFG_OFF[g]);
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == A_REG);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q_o[g] <= '0;
      else if (hit && !wr_block_i) cfg_q_o[g] <= wr_data_i;
    end

    // R4
    blocked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && wr_block_i) |=> $stable(cfg_q_o[g]));
  end
endmodule

// File: rtl/spi_wp_rdport.sv
module spi_wp_rdport
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_en_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q_i,
  input  logic                           prot_en_i,
  input  logic                           viol_flag_i,
  input  logic [ADDR_W-1:0]              viol_src_i,
  output logic [DATA_W-1:0]              rd_data_o
);
  logic [DATA_W-1:0] sel;
  logic              mapped;

  always_comb begin
    sel    = '0;
    mapped = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (rd_addr_i == ADDR_W'(CFG_OFF[i])) begin
        sel    = cfg_q_i[i];
        mapped = 1'b1;
      end
    end
    if (rd_addr_i == ADDR_W'(OFF_CTRL)) begin
      sel[0] = prot_en_i;
      mapped = 1'b1;
    end
    if (rd_addr_i == ADDR_W'(OFF_STAT)) begin
      sel[0]                = viol_flag_i;
      sel[SRC_LSB +: ADDR_W] = viol_src_i;
      mapped                = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= sel;
    else              rd_data_o <= '0;
  end

  // R11
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !mapped) |=> (rd_data_o == '0));
  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rd_data_o == '0));
endmodule

// File: rtl/spi_wp_top.sv
module spi_wp_top
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic                           prot_en;
  logic                           wr_block;
  logic                           viol_flag;
  logic [ADDR_W-1:0]              viol_src;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic                           stat_rd;

  assign stat_rd = rd_en_i && (rd_addr_i == ADDR_W'(OFF_STAT));

  spi_wp_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .en_wdata_i  (wr_data_i[0]),
    .stat_rd_i   (stat_rd),
    .prot_en_o   (prot_en),
    .wr_block_o  (wr_block),
    .viol_flag_o (viol_flag),
    .viol_src_o  (viol_src)
  );

  spi_wp_cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wr_block_i (wr_block),
    .cfg_q_o    (cfg_q)
  );

  spi_wp_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .cfg_q_i     (cfg_q),
    .prot_en_i   (prot_en),
    .viol_flag_i (viol_flag),
    .viol_src_i  (viol_src),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: tb/spi_wp_top_tb.sv
`timescale 1ns/1ps
module spi_wp_top_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              rd_en_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // reference state
  logic [31:0] m_mode, m_tx, m_cs, exp_rd;
  logic        m_en, m_flag;
  logic [7:0]  m_src;

  always #2.5 clk_i = ~clk_i;

  spi_wp_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_tx = 0; m_cs = 0; m_en = 0; m_flag = 0; m_src = 0; exp_rd = 0;
    end else begin
      logic [31:0] v;
      logic        viol;
      v = 0;
      case (rd_addr_i)
        8'h04: v = m_mode;
        8'h08: v = m_tx;
        8'h10: v = m_cs;
        8'h20: v = {31'd0, m_en};
        8'h24: v = {16'd0, m_src, 7'd0, m_flag};
        default: v = 0;
      endcase
      exp_rd = rd_en_i ? v : 32'd0;
      viol = wr_en_i && m_en && (wr_addr_i == 8'h04 || wr_addr_i == 8'h10);
      if (wr_en_i) begin
        case (wr_addr_i)
          8'h04: if (!m_en) m_mode = wr_data_i;
          8'h08: m_tx = wr_data_i;
          8'h10: if (!m_en) m_cs = wr_data_i;
          8'h20: m_en = wr_data_i[0];
          default: ;
        endcase
      end
      if (viol) begin
        m_flag = 1; m_src = wr_addr_i;
      end else if (rd_en_i && rd_addr_i == 8'h24) begin
        m_flag = 0;
      end
    end
  end

  task automatic check_out();
    checks++;
    if (rd_data_o !== exp_rd) begin
      errors++;
      $display("FAIL %s: rd_data_o=%h expected %h at %0t", cur_req, rd_data_o, exp_rd, $time);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                      input bit re, input logic [7:0] ra, input string req);
    cur_req   = req;
    wr_en_i   = we;
    wr_addr_i = wa;
    wr_data_i = wd;
    rd_en_i   = re;
    rd_addr_i = ra;
    @(posedge clk_i);
    @(negedge clk_i);
    check_out();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    step(1, a, d, 0, 8'h00, req);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(0, 8'h00, 0, 1, a, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run incomplete, actual hung expected finished");
    finish_run();
  end

  initial begin
    #12;
    cur_req = "R1";
    check_out();
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h10, "R1"); rd(8'h20, "R1"); rd(8'h24, "R1");
    step(0, 0, 0, 0, 0, "R11");
    // unprotected writes
    wr(8'h04, 32'h0000_00A5, "R3");
    wr(8'h10, 32'h0000_003C, "R3");
    wr(8'h08, 32'h0000_0077, "R5");
    rd(8'h04, "R3"); rd(8'h10, "R3"); rd(8'h08, "R5");
    rd(8'h24, "R6");
    // enable protection, upper bits must read zero
    wr(8'h20, 32'hFFFF_FFFF, "R2");
    rd(8'h20, "R2");
    // blocked write
    wr(8'h04, 32'h1111_1111, "R4");
    rd(8'h04, "R4");
    rd(8'h24, "R6");
    rd(8'h24, "R8");
    // two violations without a read: last source wins
    wr(8'h10, 32'h2222_2222, "R4");
    wr(8'h04, 32'h3333_3333, "R7");
    rd(8'h10, "R4");
    rd(8'h24, "R7");
    wr(8'h10, 32'h4444_4444, "R7");
    rd(8'h24, "R7");
    // unguarded write under protection
    wr(8'h08, 32'hDEAD_BEEF, "R5");
    rd(8'h08, "R5");
    rd(8'h24, "R5");
    // violation together with a status read
    wr(8'h04, 32'h5555_5555, "R9");
    step(1, 8'h10, 32'h6666_6666, 1, 8'h24, "R9");
    rd(8'h24, "R9");
    rd(8'h24, "R8");
    // unmapped and read-only addresses
    wr(8'h30, 32'hFFFF_FFFF, "R11");
    rd(8'h30, "R11");
    wr(8'h24, 32'hFFFF_FFFF, "R11");
    rd(8'h24, "R11");
    step(1, 8'h08, 32'h0BAD_F00D, 1, 8'h08, "R11");
    rd(8'h08, "R11");
    // drop protection and write immediately
    wr(8'h20, 32'h0, "R10");
    wr(8'h04, 32'h0000_0022, "R10");
    wr(8'h10, 32'h0000_0033, "R10");
    rd(8'h04, "R10"); rd(8'h10, "R10"); rd(8'h20, "R2"); rd(8'h24, "R10");
    // re-enable and read while idle
    wr(8'h20, 32'h1, "R2");
    rd(8'h20, "R2");
    step(0, 0, 0, 0, 0, "R11");
    finish_run();
  end
endmodule